// File: doc/BRIEF.md
# Debug/Trace Domain Power Sequencer

This controller sequences a shared power domain that holds debug and trace logic. The domain is reset from two unrelated clocks: a peripheral-bus clock and a trace-bus clock. The controller drives an active-low reset into each of them, a shared output clamp and a power-switch enable, and it watches a power-good input. A power-down request asserts both resets in the same cycle. The sequencer then waits until each reset has been held for a minimum number of cycles of its own clock, raises the clamp and only then switches power off. Both resets stay asserted for as long as the domain is unpowered.

A power-up request turns the switch on while the clamp and both resets are held. The clamp is released only after power-good has been seen. From then on, each reset follows its own release enable. When the debug domain is up and the core reports that it is off, an error flag tells the debugger that the core is powered down.

A power-down request that arrives during a power-up is remembered and carried out once the domain is fully up. Each reset-hold count runs in the clock of the reset it measures. The result crosses back into the controller clock through a two-flop synchronizer.

Top module: `dbg_pwr_seq`

## Requirements
- R1: After rst_ni the domain is off: pwr_en_o=0, clamp_o=1, bus_rst_no=0, trc_rst_no=0, core_off_err_o=0.
- R2: A down_req_i pulse while the domain is up drives bus_rst_no and trc_rst_no low in the same cycle, with power still on and the clamp still off.
- R3: clamp_o rises only after bus_rst_no has been low for at least HOLD_CYC (default 8) bus_clk_i cycles and trc_rst_no has been low for at least HOLD_CYC trc_clk_i cycles.
- R4: pwr_en_o falls only after clamp_o is high. While pwr_en_o is low, clamp_o stays high and both resets stay low.
- R5: An up_req_i pulse while off raises pwr_en_o with the clamp and both resets held. clamp_o falls only after pwr_good_i is high, and the resets stay low through the cycle in which the clamp falls.
- R6: Once the domain is up, bus_rst_no equals bus_rel_en_i and trc_rst_no equals trc_rel_en_i, each independently of the other.
- R7: core_off_err_o is high exactly while the domain is up (power on, clamp off) and core_on_i is low.
- R8: A down_req_i pulse received while power-up is in progress is held, and the power-down runs right after the domain comes up.
- R9: up_req_i has no effect while the domain is up, and down_req_i has no effect while it is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_clk_i | input | 1 | Peripheral-bus clock of the domain |
| trc_clk_i | input | 1 | Trace-bus clock of the domain |
| up_req_i | input | 1 | Power-up request pulse |
| down_req_i | input | 1 | Power-down request pulse |
| pwr_good_i | input | 1 | Domain supply is stable (asynchronous) |
| bus_rel_en_i | input | 1 | Allows the bus-clock reset to be released |
| trc_rel_en_i | input | 1 | Allows the trace-clock reset to be released |
| core_on_i | input | 1 | Core power domain is on |
| pwr_en_o | output | 1 | Power-switch enable |
| clamp_o | output | 1 | Shared output clamp enable |
| bus_rst_no | output | 1 | Active-low reset, bus-clock domain |
| trc_rst_no | output | 1 | Active-low reset, trace-clock domain |
| core_off_err_o | output | 1 | Core-powered-down indication to the debugger |

## Verification
A full power-down from a released state, run with two unrelated domain clocks, shows whether the clamp waits for the slower domain's hold count rather than the faster one's. Power-up is tried once with power-good delayed and once with it already high, which separates a sequencer that waits for power-good from one that just steps through. Releases are tried with one enable at a time and then both, and the error flag is toggled both with the domain up and with it off. A down request given during a stalled power-up checks that the request is remembered, and stray requests in the opposite state check that they are ignored.

// File: rtl/dbg_pwr_pkg.sv
package dbg_pwr_pkg;
  localparam int NDOM = 2;  // index 0: bus clock, 1: trace clock

  typedef enum logic [2:0] {
    S_OFF,
    S_PWR_UP,
    S_UNCLAMP,
    S_ON,
    S_RST_HOLD,
    S_CLAMP
  } seq_state_e;
endpackage

// File: rtl/dbg_sync2.sv
module dbg_sync2 #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/dbg_rst_hold.sv
module dbg_rst_hold #(
  parameter int HOLD_CYC = 8
) (
  input  logic dom_clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic done_o
);
  localparam int CW = $clog2(HOLD_CYC + 1);

  logic          req_s;
  logic [CW-1:0] cnt_q;

  dbg_sync2 #(.W(1)) u_req_sync (
    .clk_i (dom_clk_i),
    .rst_ni(rst_ni),
    .d_i   (req_i),
    .q_o   (req_s)
  );

  // Counts own-clock cycles after the synchronized request; conservative bound.
  always_ff @(posedge dom_clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (!req_s)                 cnt_q <= '0;
    else if (cnt_q != CW'(HOLD_CYC)) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == CW'(HOLD_CYC));
endmodule

// File: rtl/dbg_pwr_seq.sv
module dbg_pwr_seq
  import dbg_pwr_pkg::*;
#(
  parameter int HOLD_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_clk_i,
  input  logic trc_clk_i,
  input  logic up_req_i,
  input  logic down_req_i,
  input  logic pwr_good_i,
  input  logic bus_rel_en_i,
  input  logic trc_rel_en_i,
  input  logic core_on_i,
  output logic pwr_en_o,
  output logic clamp_o,
  output logic bus_rst_no,
  output logic trc_rst_no,
  output logic core_off_err_o
);
  seq_state_e      state_q, state_d;
  logic            pend_q, pend_d;
  logic            pg_s;
  logic            hold_req;
  logic [NDOM-1:0] dom_clk;
  logic [NDOM-1:0] done_dom;
  logic [NDOM-1:0] done_s;
  logic            all_done, any_done, dom_up, in_power_up;

  assign dom_clk = {trc_clk_i, bus_clk_i};
  assign hold_req = (state_q == S_RST_HOLD);

  for (genvar d = 0; d < NDOM; d++) begin : g_dom
    dbg_rst_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
      .dom_clk_i(dom_clk[d]),
      .rst_ni   (rst_ni),
      .req_i    (hold_req),
      .done_o   (done_dom[d])
    );

    dbg_sync2 #(.W(1)) u_done_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (done_dom[d]),
      .q_o   (done_s[d])
    );
  end

  dbg_sync2 #(.W(1)) u_pg_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pwr_good_i),
    .q_o   (pg_s)
  );

  assign all_done    = &done_s;
  assign any_done    = |done_s;
  assign in_power_up = (state_q == S_PWR_UP) || (state_q == S_UNCLAMP);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_OFF:      if (up_req_i) state_d = S_PWR_UP;
      S_PWR_UP:   if (pg_s) state_d = S_UNCLAMP;
      S_UNCLAMP:  state_d = S_ON;
      // stale hold flags from the last cycle must clear before a new count
      S_ON:       if ((down_req_i || pend_q) && !any_done) state_d = S_RST_HOLD;
      S_RST_HOLD: if (all_done) state_d = S_CLAMP;
      S_CLAMP:    state_d = S_OFF;
      default:    state_d = S_OFF;
    endcase
  end

  always_comb begin
    pend_d = pend_q;
    if (state_d == S_RST_HOLD || state_q == S_OFF) pend_d = 1'b0;
    else if (down_req_i && (in_power_up || state_q == S_ON)) pend_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_OFF;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
    end
  end

  assign dom_up         = (state_q == S_ON);
  assign pwr_en_o       = (state_q != S_OFF);
  assign clamp_o        = (state_q == S_OFF) || (state_q == S_PWR_UP) || (state_q == S_CLAMP);
  assign bus_rst_no     = dom_up && bus_rel_en_i;
  assign trc_rst_no     = dom_up && trc_rel_en_i;
  assign core_off_err_o = dom_up && !core_on_i;
endmodule

// File: rtl/dbg_pwr_seq_chk.sv
module dbg_pwr_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bus_rel_en_i,
  input logic trc_rel_en_i,
  input logic core_on_i,
  input logic pwr_en_o,
  input logic clamp_o,
  input logic bus_rst_no,
  input logic trc_rst_no,
  input logic core_off_err_o
);
  a_r3_rst_before_clamp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clamp_o) |-> (!bus_rst_no && !trc_rst_no && $past(!bus_rst_no && !trc_rst_no)));

  a_r4_off_is_safe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_en_o |-> (clamp_o && !bus_rst_no && !trc_rst_no));

  a_r4_clamp_before_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pwr_en_o) |-> $past(clamp_o));

  a_r5_unclamp_powered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clamp_o) |-> (pwr_en_o && $past(pwr_en_o) && !bus_rst_no && !trc_rst_no));

  a_r6_bus_release_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rst_no |-> (bus_rel_en_i && pwr_en_o && !clamp_o));

  a_r6_trc_release_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trc_rst_no |-> (trc_rel_en_i && pwr_en_o && !clamp_o));

  a_r7_err_scope: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_off_err_o |-> (!core_on_i && pwr_en_o && !clamp_o));
endmodule

bind dbg_pwr_seq dbg_pwr_seq_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .bus_rel_en_i  (bus_rel_en_i),
  .trc_rel_en_i  (trc_rel_en_i),
  .core_on_i     (core_on_i),
  .pwr_en_o      (pwr_en_o),
  .clamp_o       (clamp_o),
  .bus_rst_no    (bus_rst_no),
  .trc_rst_no    (trc_rst_no),
  .core_off_err_o(core_off_err_o)
);

// File: tb/dbg_pwr_seq_bench.sv
`timescale 1ns/1ps
module dbg_pwr_seq_bench;
  localparam int HOLD = 8;

  logic clk_i = 1'b0, bus_clk_i = 1'b0, trc_clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic up_req_i = 1'b0, down_req_i = 1'b0, pwr_good_i = 1'b0;
  logic bus_rel_en_i = 1'b0, trc_rel_en_i = 1'b0, core_on_i = 1'b1;
  logic pwr_en_o, clamp_o, bus_rst_no, trc_rst_no, core_off_err_o;

  always #2 clk_i = ~clk_i;
  always #5 bus_clk_i = ~bus_clk_i;
  always #7 trc_clk_i = ~trc_clk_i;

  dbg_pwr_seq #(.HOLD_CYC(HOLD)) u_dbg_pwr_seq (.*);

  // vector: {pwr_en, clamp, bus_rst_n, trc_rst_n, err}
  logic [4:0] vec;
  assign vec = {pwr_en_o, clamp_o, bus_rst_no, trc_rst_no, core_off_err_o};

  logic [4:0] exp_q[$];
  string      tag_q[$];
  int n_chk = 0, n_err = 0;
  bit mon_en = 0, finished = 0;
  logic [4:0] last_vec;
  int bus_low = 0, trc_low = 0;

  always @(posedge bus_clk_i) bus_low = bus_rst_no ? 0 : bus_low + 1;
  always @(posedge trc_clk_i) trc_low = trc_rst_no ? 0 : trc_low + 1;

  task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic push(input logic [4:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  // monitor: every output change must match the head of the scoreboard
  always @(negedge clk_i) begin
    if (mon_en && vec !== last_vec) begin
      if (vec[3] && !last_vec[3]) begin
        n_chk++;
        if (bus_low < HOLD || trc_low < HOLD) begin
          n_err++;
          $display("FAIL R3: actual bus_hold=%0d trc_hold=%0d expected >=%0d each",
                   bus_low, trc_low, HOLD);
        end
      end
      if (exp_q.size() == 0) begin
        n_chk++; n_err++;
        $display("FAIL unexpected change: actual=%b expected=%b", vec, last_vec);
      end else begin
        chk(tag_q.pop_front(), vec, exp_q.pop_front());
      end
      last_vec = vec;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic pulse_up();
    @(posedge clk_i); #1 up_req_i = 1'b1;
    @(posedge clk_i); #1 up_req_i = 1'b0;
  endtask

  task automatic pulse_down();
    @(posedge clk_i); #1 down_req_i = 1'b1;
    @(posedge clk_i); #1 down_req_i = 1'b0;
  endtask

  task automatic drain(input string tag);
    int w = 0;
    while (exp_q.size() != 0 && w < 3000) begin
      @(posedge clk_i);
      w++;
    end
    n_chk++;
    if (exp_q.size() != 0) begin
      n_err++;
      $display("FAIL %s: actual pending=%0d expected pending=0 (next %b)",
               tag, exp_q.size(), exp_q[0]);
      exp_q.delete();
      tag_q.delete();
    end
    tick(20);
  endtask

  task automatic go_down(input logic [4:0] on_vec);
    push(5'b10000, "R2 both resets assert");
    push(5'b11000, "R3 clamp after hold");
    push(5'b01000, "R4 power removed");
    pulse_down();
    drain("R4 down sequence");
  endtask

  initial begin
    tick(5);
    @(negedge clk_i);
    chk("R1 reset state", vec, 5'b01000);
    last_vec = vec;
    rst_ni = 1'b1;
    tick(3);
    mon_en = 1;

    // R5: power-up with delayed power-good
    bus_rel_en_i = 1'b1; trc_rel_en_i = 1'b1;
    push(5'b11000, "R5 switch on, clamp held");
    pulse_up();
    tick(30);
    @(negedge clk_i) chk("R5 clamp held without power-good", vec, 5'b11000);
    push(5'b10000, "R5 clamp released");
    push(5'b10110, "R6 both released");
    pwr_good_i = 1'b1;
    drain("R5 power-up");

    // R9: up request while up
    pulse_up();
    tick(30);
    @(negedge clk_i) chk("R9 up_req ignored when up", vec, 5'b10110);

    // R7: error flag with domain up
    push(5'b10111, "R7 err on core off");
    core_on_i = 1'b0;
    drain("R7 set");
    push(5'b10110, "R7 err clears");
    core_on_i = 1'b1;
    drain("R7 clear");

    // R2/R3/R4 power-down
    go_down(5'b10110);
    tick(60);
    @(negedge clk_i) chk("R4 resets held while off", vec, 5'b01000);
    core_on_i = 1'b0;
    tick(5);
    @(negedge clk_i) chk("R7 no err while off", vec, 5'b01000);
    core_on_i = 1'b1;
    pulse_down();
    tick(40);
    @(negedge clk_i) chk("R9 down_req ignored when off", vec, 5'b01000);

    // R6: independent release, power-good already high
    bus_rel_en_i = 1'b1; trc_rel_en_i = 1'b0;
    push(5'b11000, "R5 switch on");
    push(5'b10000, "R5 clamp released");
    push(5'b10100, "R6 bus only");
    pulse_up();
    drain("R6 bus only");
    push(5'b10110, "R6 trace joins");
    trc_rel_en_i = 1'b1;
    drain("R6 trace");
    push(5'b10010, "R6 bus held alone");
    bus_rel_en_i = 1'b0;
    drain("R6 bus reasserted");
    push(5'b10110, "R6 bus released again");
    bus_rel_en_i = 1'b1;
    drain("R6 both");

    go_down(5'b10110);

    // R8: down request during stalled power-up
    pwr_good_i = 1'b0;
    tick(10);
    push(5'b11000, "R8 switch on");
    pulse_up();
    tick(10);
    pulse_down();
    tick(20);
    @(negedge clk_i) chk("R8 still waiting for power-good", vec, 5'b11000);
    push(5'b10000, "R8 clamp released");
    push(5'b10110, "R8 domain up");
    push(5'b10000, "R8 held request: resets assert");
    push(5'b11000, "R8 clamp");
    push(5'b01000, "R8 power removed");
    pwr_good_i = 1'b1;
    drain("R8 held down");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule